// File: doc/BRIEF.md
# Dual-Lane SAR ADC Serial Host

This block is a serial host for a simultaneous-sampling converter that has two serial result outputs. A client hands it one command at a time on a request/acknowledge port: an opcode (no-op, register read, register write), a register address and write data. The host turns each command into one chip-select frame. During the frame it shifts the 16-bit command out MSB first and collects the converter's result bits on one or both result lanes. Every falling edge of chip-select starts a new conversion in the converter. The data that comes back in a frame belongs to the conversion started by the frame before. If the frame before carried a register read, the data is that register's contents instead. A client streams conversions by issuing no-op commands back to back. It reads a register by issuing the read and then one more command, whose frame returns the data.

The serial clock idles high and is derived from the system clock. Each clock level lasts a programmable number of system cycles. Chip-select stays high for a programmable minimum between frames. The host keeps a copy of the converter's output-lane mode and updates it from the writes it sends. In dual-lane mode a frame is 16 clocks long and each lane carries one 16-bit word. In single-lane mode a frame is 32 clocks long: both words arrive back to back on lane A and lane B is ignored. A soft-reset write returns the copy to dual-lane mode.

The frame engine has three states. ST_IDLE keeps chip-select high and counts the gap. When a request is accepted it goes to ST_HIGH, lowering chip-select and presenting the first command bit. ST_HIGH holds the clock high; at the end of the half period it samples the lanes and goes to ST_LOW, driving the clock low. ST_LOW holds the clock low; at the end of the half period it raises the clock. From there it returns to ST_HIGH with the next command bit when more bits remain, or to ST_IDLE after the last bit, raising chip-select. The lane tracker has two states, LANE_DUAL and LANE_SINGLE. It moves to LANE_SINGLE on a mode write with the mode bit set. It moves back to LANE_DUAL on a mode write with the bit clear, or on a soft-reset write. It changes state only at a frame's end.

Top module: `adc_spi_host`

## Requirements
- R1: While reset is asserted, chip-select and the serial clock are high, data-in is low, and the acknowledge, result-valid and register-data flag outputs are low. The lane mode after reset is dual-lane.
- R2: A request is accepted only in ST_IDLE once the gap has elapsed. Acceptance gives a one-cycle acknowledge in the same cycle that chip-select falls, and a request held during a frame is not accepted until that frame ends.
- R3: The command word is 16 bits: opcode in bits 15:14 (00 no-op, 01 read, 10 write), address in bits 13:10, data in bits 9:0. A no-op sends all zeros, a read sends a zero data field, and a write sends all fields. The word goes out MSB first.
- R4: The serial clock is high whenever chip-select is high. Each clock level inside a frame lasts max(cfg_half,1) system cycles, and the first falling edge comes that long after chip-select falls. A frame has 16 falling edges in dual-lane mode and 32 in single-lane mode, and chip-select rises together with the final rising edge.
- R5: Data-in changes only when chip-select falls or the clock rises, so it is stable while the clock is low. Bits 16 to 31 of a single-lane frame are zero.
- R6: Each result bit is sampled on the system edge that ends a high clock phase, MSB first. This makes the MSB, which is present from chip-select fall, the first bit taken.
- R7: In dual-lane mode res_a is the 16 bits from lane A and res_b the 16 bits from lane B.
- R8: In single-lane mode the first 16 bits on lane A form res_a and the next 16 form res_b, and lane B has no effect.
- R9: A write to address 2 sets single-lane mode when its data bit 0 is 1 and dual-lane mode when it is 0. The new mode applies from the next frame on.
- R10: A write to address 3 with data bit 0 set is a soft reset, and it returns the lane mode to dual-lane from the next frame on.
- R11: res_valid pulses for one cycle in the cycle chip-select rises, for every frame except the first after reset. res_reg is high with it when the previous frame carried a read.
- R12: Chip-select stays high for at least cfg_gap+1 system cycles between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_half | input | HALF_W | System cycles per serial clock level (0 acts as 1) |
| cfg_gap | input | GAP_W | Extra minimum chip-select high cycles between frames |
| cmd_req | input | 1 | Command request |
| cmd_op | input | 2 | Opcode: 00 no-op, 01 read, 10 write |
| cmd_addr | input | 4 | Register address |
| cmd_wdata | input | 10 | Register write data |
| cmd_ack | output | 1 | One-cycle acceptance pulse |
| res_valid | output | 1 | Result words valid (one cycle) |
| res_reg | output | 1 | Result words carry register data |
| res_a | output | 16 | First result word |
| res_b | output | 16 | Second result word |
| adc_cs_n | output | 1 | Chip-select, active low |
| adc_sclk | output | 1 | Serial clock, idle high |
| adc_sdi | output | 1 | Command data to the converter |
| adc_sdo_a | input | 1 | Result lane A |
| adc_sdo_b | input | 1 | Result lane B |

## Verification
If the lane-mode copy is wrong, the next frame has the wrong number of clock edges, and the converter model sees this when that frame's chip-select rises. The returned words come out shuffled in the same cycle. A wrong bit or phase counter shows at once as a clock level of the wrong length, or as data-in moving while the clock is low; both are compared every cycle. A lost read marker or first-frame flag shows on the very next res_valid pulse as a wrong res_reg or an extra or missing result.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
    localparam int WORD_W  = 16;
    localparam int OP_W    = 2;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 10;
    localparam int LONG_W  = 2 * WORD_W;
    localparam int BIDX_W  = $clog2(LONG_W);

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } frame_st_e;

    typedef enum logic {
        LANE_DUAL   = 1'b0,
        LANE_SINGLE = 1'b1
    } lane_e;

    function automatic logic [WORD_W-1:0] build_word(
        input op_e op, input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] data);
        logic [WORD_W-1:0] w;
        unique case (op)
            OP_NOP:  w = '0;
            OP_READ: w = {op, addr, {DATA_W{1'b0}}};
            default: w = {op, addr, data};
        endcase
        return w;
    endfunction
endpackage

// File: rtl/adc_frame_fsm.sv
module adc_frame_fsm
    import adc_host_pkg::*;
#(
    parameter int HALF_W = 8,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic              cmd_req,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              one_wire,
    output logic              cmd_ack,
    output logic              cs_n,
    output logic              sclk,
    output logic              sdi,
    output logic              sample_stb,
    output logic              frame_end,
    output logic              frame_1w,
    output logic [WORD_W-1:0] frame_word
);
    frame_st_e           state, state_nx;
    logic [HALF_W-1:0]   cnt;
    logic [HALF_W-1:0]   half_q;
    logic [GAP_W-1:0]    gap_cnt;
    logic [BIDX_W-1:0]   bit_idx;
    logic [LONG_W-1:0]   tx;
    logic                half_end;
    logic                last_bit;
    logic                gap_ok;
    logic                accept;

    always_comb begin
        half_end   = (cnt == half_q - HALF_W'(1));
        last_bit   = (bit_idx == (frame_1w ? BIDX_W'(LONG_W - 1) : BIDX_W'(WORD_W - 1)));
        gap_ok     = (gap_cnt >= cfg_gap);
        accept     = (state == ST_IDLE) && cmd_req && gap_ok;
        sample_stb = (state == ST_HIGH) && half_end;
        frame_end  = (state == ST_LOW) && half_end && last_bit;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)   state_nx = ST_HIGH;
            ST_HIGH: if (half_end) state_nx = ST_LOW;
            ST_LOW:  if (half_end) state_nx = last_bit ? ST_IDLE : ST_HIGH;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n       <= 1'b1;
            sclk       <= 1'b1;
            sdi        <= 1'b0;
            cmd_ack    <= 1'b0;
            cnt        <= '0;
            half_q     <= HALF_W'(1);
            gap_cnt    <= '0;
            bit_idx    <= '0;
            tx         <= '0;
            frame_1w   <= 1'b0;
            frame_word <= '0;
        end else begin
            cmd_ack <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (!gap_ok) gap_cnt <= gap_cnt + GAP_W'(1);
                    if (accept) begin
                        cs_n       <= 1'b0;
                        cmd_ack    <= 1'b1;
                        sdi        <= cmd_word[WORD_W-1];
                        tx         <= {cmd_word[WORD_W-2:0], {(LONG_W-WORD_W+1){1'b0}}};
                        frame_word <= cmd_word;
                        frame_1w   <= one_wire;
                        half_q     <= (cfg_half == '0) ? HALF_W'(1) : cfg_half;
                        cnt        <= '0;
                        bit_idx    <= '0;
                    end
                end
                ST_HIGH: begin
                    if (half_end) begin
                        sclk <= 1'b0;
                        cnt  <= '0;
                    end else begin
                        cnt <= cnt + HALF_W'(1);
                    end
                end
                ST_LOW: begin
                    if (half_end) begin
                        sclk <= 1'b1;
                        cnt  <= '0;
                        if (last_bit) begin
                            cs_n    <= 1'b1;
                            sdi     <= 1'b0;
                            gap_cnt <= '0;
                        end else begin
                            bit_idx <= bit_idx + BIDX_W'(1);
                            sdi     <= tx[LONG_W-1];
                            tx      <= {tx[LONG_W-2:0], 1'b0};
                        end
                    end else begin
                        cnt <= cnt + HALF_W'(1);
                    end
                end
                default: cs_n <= 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/adc_lane_capture.sv
module adc_lane_capture
    import adc_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic              frame_end,
    input  logic              frame_1w,
    input  logic              sdo_a,
    input  logic              sdo_b,
    output logic [WORD_W-1:0] res_a,
    output logic [WORD_W-1:0] res_b
);
    logic [LONG_W-1:0] sh_a;
    logic [WORD_W-1:0] sh_b;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_a <= '0;
            sh_b <= '0;
        end else if (sample_stb) begin
            sh_a <= {sh_a[LONG_W-2:0], sdo_a};
            sh_b <= {sh_b[WORD_W-2:0], sdo_b};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_a <= '0;
            res_b <= '0;
        end else if (frame_end) begin
            if (frame_1w) begin
                res_a <= sh_a[LONG_W-1:WORD_W];
                res_b <= sh_a[WORD_W-1:0];
            end else begin
                res_a <= sh_a[WORD_W-1:0];
                res_b <= sh_b;
            end
        end
    end
endmodule

// File: rtl/adc_mode_track.sv
module adc_mode_track
    import adc_host_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MODE_ADDR = 4'd2,
    parameter int                MODE_BIT  = 0,
    parameter logic [ADDR_W-1:0] RST_ADDR  = 4'd3,
    parameter int                RST_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end,
    input  logic [WORD_W-1:0] frame_word,
    output logic              one_wire,
    output logic              res_valid,
    output logic              res_reg
);
    lane_e             lane, lane_nx;
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              is_wr;
    logic              set_1w, clr_1w, soft_rst;
    logic              seen_frame;
    logic              prev_read;

    always_comb begin
        op       = op_e'(frame_word[WORD_W-1 -: OP_W]);
        addr     = frame_word[DATA_W +: ADDR_W];
        data     = frame_word[DATA_W-1:0];
        is_wr    = frame_end && (op == OP_WRITE);
        set_1w   = is_wr && (addr == MODE_ADDR) && data[MODE_BIT];
        clr_1w   = is_wr && (addr == MODE_ADDR) && !data[MODE_BIT];
        soft_rst = is_wr && (addr == RST_ADDR) && data[RST_BIT];
        lane_nx  = lane;
        unique case (lane)
            LANE_DUAL:   if (set_1w && !soft_rst)  lane_nx = LANE_SINGLE;
            LANE_SINGLE: if (clr_1w || soft_rst)   lane_nx = LANE_DUAL;
            default:     lane_nx = LANE_DUAL;
        endcase
        one_wire = (lane == LANE_SINGLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lane <= LANE_DUAL;
        else        lane <= lane_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_frame <= 1'b0;
            prev_read  <= 1'b0;
            res_valid  <= 1'b0;
            res_reg    <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (frame_end) begin
                res_valid  <= seen_frame;
                res_reg    <= prev_read;
                seen_frame <= 1'b1;
                prev_read  <= (op == OP_READ);
            end
        end
    end
endmodule

// File: rtl/adc_spi_host.sv
module adc_spi_host
    import adc_host_pkg::*;
#(
    parameter int HALF_W = 8,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic              cmd_req,
    input  logic [1:0]        cmd_op,
    input  logic [3:0]        cmd_addr,
    input  logic [9:0]        cmd_wdata,
    output logic              cmd_ack,
    output logic              res_valid,
    output logic              res_reg,
    output logic [15:0]       res_a,
    output logic [15:0]       res_b,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    output logic              adc_sdi,
    input  logic              adc_sdo_a,
    input  logic              adc_sdo_b
);
    logic [WORD_W-1:0] cmd_word;
    logic [WORD_W-1:0] frame_word;
    logic              one_wire;
    logic              sample_stb;
    logic              frame_end;
    logic              frame_1w;

    assign cmd_word = build_word(op_e'(cmd_op), cmd_addr, cmd_wdata);

    adc_frame_fsm #(.HALF_W(HALF_W), .GAP_W(GAP_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_half   (cfg_half),
        .cfg_gap    (cfg_gap),
        .cmd_req    (cmd_req),
        .cmd_word   (cmd_word),
        .one_wire   (one_wire),
        .cmd_ack    (cmd_ack),
        .cs_n       (adc_cs_n),
        .sclk       (adc_sclk),
        .sdi        (adc_sdi),
        .sample_stb (sample_stb),
        .frame_end  (frame_end),
        .frame_1w   (frame_1w),
        .frame_word (frame_word)
    );

    adc_lane_capture i_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .frame_end  (frame_end),
        .frame_1w   (frame_1w),
        .sdo_a      (adc_sdo_a),
        .sdo_b      (adc_sdo_b),
        .res_a      (res_a),
        .res_b      (res_b)
    );

    adc_mode_track i_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end  (frame_end),
        .frame_word (frame_word),
        .one_wire   (one_wire),
        .res_valid  (res_valid),
        .res_reg    (res_reg)
    );
endmodule

// File: rtl/adc_spi_host_chk.sv
module adc_spi_host_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_req,
    input logic cmd_ack,
    input logic res_valid,
    input logic adc_cs_n,
    input logic adc_sclk,
    input logic adc_sdi
);
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ack |=> !cmd_ack); // R2
    AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ack |-> $past(cmd_req)); // R2
    AST_ACK_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ack |-> $fell(adc_cs_n)); // R2
    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> adc_sclk); // R4
    AST_CS_FALL_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> adc_sclk); // R4
    AST_SDI_HELD_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_sclk |-> $stable(adc_sdi)); // R5
    AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $rose(adc_cs_n)); // R11
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R11
endmodule

bind adc_spi_host adc_spi_host_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_req   (cmd_req),
    .cmd_ack   (cmd_ack),
    .res_valid (res_valid),
    .adc_cs_n  (adc_cs_n),
    .adc_sclk  (adc_sclk),
    .adc_sdi   (adc_sdi)
);

// File: tb/test_adc_spi_host.sv
`timescale 1ns/1ps
module test_adc_spi_host;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_half = 8'd2;
    logic [7:0]  cfg_gap = 8'd3;
    logic        cmd_req = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [3:0]  cmd_addr = 4'h0;
    logic [9:0]  cmd_wdata = 10'h0;
    logic        cmd_ack, res_valid, res_reg;
    logic [15:0] res_a, res_b;
    logic        adc_cs_n, adc_sclk, adc_sdi;
    logic        adc_sdo_a = 1'b0;
    logic        adc_sdo_b = 1'b0;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    adc_spi_host i_adc_spi_host (
        .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_gap(cfg_gap),
        .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_ack(cmd_ack), .res_valid(res_valid), .res_reg(res_reg),
        .res_a(res_a), .res_b(res_b), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
        .adc_sdi(adc_sdi), .adc_sdo_a(adc_sdo_a), .adc_sdo_b(adc_sdo_b)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected command word, written from the R3 encoding
    function automatic logic [15:0] ref_word(input logic [1:0] op, input logic [3:0] a,
                                             input logic [9:0] d);
        if (op == 2'b00) return 16'h0000;
        if (op == 2'b01) return {op, a, 10'h000};
        return {op, a, d};
    endfunction

    function automatic logic [15:0] conv_a(input int k);
        return 16'(k * 40503 + 32'h1234);
    endfunction
    function automatic logic [15:0] conv_b(input int k);
        return 16'((k * 12289) ^ 32'hC3A5);
    endfunction

    // ---------------- converter model ----------------
    logic [15:0] word_q[$];
    logic [15:0] exp_a_q[$];
    logic [15:0] exp_b_q[$];
    bit          exp_reg_q[$];
    logic [9:0]  regs [16];
    bit          dev_1w = 1'b0;
    bit          dev_active = 1'b0;
    bit          frame_1w = 1'b0;
    bit          rd_pend = 1'b0;
    logic [3:0]  rd_addr = 4'h0;
    logic [31:0] la, lb, rx;
    int          pos = 0;
    int          falls = 0;
    int          conv_idx = 0;
    int          dev_frames = 0;

    initial for (int i = 0; i < 16; i++) regs[i] = 10'h0;

    always @(negedge adc_cs_n) if (rst_n) begin
        logic [15:0] wa, wb;
        bit isreg;
        dev_active = 1'b1;
        frame_1w = dev_1w;
        if (rd_pend) begin
            wa = {6'b0, regs[rd_addr]}; wb = 16'h0000; isreg = 1'b1;
        end else begin
            wa = conv_a(conv_idx - 1); wb = conv_b(conv_idx - 1); isreg = 1'b0;
        end
        conv_idx++;
        dev_frames++;
        if (dev_frames > 1) begin
            exp_a_q.push_back(wa); exp_b_q.push_back(wb); exp_reg_q.push_back(isreg);
        end
        if (dev_1w) begin la = {wa, wb}; lb = 32'hFFFF_FFFF; end
        else        begin la = {wa, 16'h0}; lb = {wb, 16'h0}; end
        pos = 0; falls = 0; rx = 32'h0;
        adc_sdo_a = la[31];
        adc_sdo_b = lb[31];
    end

    always @(negedge adc_sclk) if (dev_active && !adc_cs_n) begin
        rx = {rx[30:0], adc_sdi};
        falls++;
        pos++;
        adc_sdo_a = (pos < 32) ? la[31-pos] : 1'b0;
        adc_sdo_b = (pos < 32) ? lb[31-pos] : 1'b0;
    end

    always @(posedge adc_cs_n) if (dev_active) begin
        logic [15:0] w, ew;
        dev_active = 1'b0;
        chk(falls == (frame_1w ? 32 : 16), "R4", "falling edges per frame",
            falls, frame_1w ? 32 : 16);
        if (frame_1w) begin
            w = rx[31:16];
            chk(rx[15:0] == 16'h0, "R5", "padding bits of single-lane frame", rx[15:0], 0);
        end else begin
            w = rx[15:0];
        end
        ew = (word_q.size() > 0) ? word_q.pop_front() : 16'hxxxx;
        chk(w === ew, "R3", "command word seen by converter", w, ew);
        rd_pend = (w[15:14] == 2'b01);
        rd_addr = w[13:10];
        if (w[15:14] == 2'b10) begin
            regs[w[13:10]] = w[9:0];
            if (w[13:10] == 4'd2) dev_1w = w[0];           // R9
            if (w[13:10] == 4'd3 && w[0]) begin             // R10
                dev_1w = 1'b0;
                regs[2] = 10'h0;
            end
        end
    end

    // ---------------- per-clock monitor ----------------
    bit m_cs_prev = 1'b1, m_sclk_prev = 1'b1, m_sdi_prev = 1'b0;
    int m_run = 0, m_hi_run = 0, acks = 0, valids = 0;

    always @(negedge clk) begin
        int half_exp;
        half_exp = (cfg_half == 8'd0) ? 1 : int'(cfg_half);
        if (rst_n) begin
            if (adc_cs_n) chk(adc_sclk === 1'b1, "R4", "clock high while deselected", adc_sclk, 1);
            if (!adc_sclk && !m_sclk_prev)
                chk(adc_sdi === m_sdi_prev, "R5", "data-in held in low phase", adc_sdi, m_sdi_prev);
            if (cmd_ack) begin
                acks++;
                chk(!adc_cs_n && m_cs_prev, "R2", "ack with chip-select fall", adc_cs_n, 0);
            end
            if (m_cs_prev && !adc_cs_n) begin
                chk(m_hi_run >= int'(cfg_gap) + 1, "R12", "chip-select high gap",
                    m_hi_run, int'(cfg_gap) + 1);
                m_run = 1;
            end else if (adc_sclk != m_sclk_prev && !m_cs_prev) begin
                chk(m_run == half_exp, "R4", "clock level length", m_run, half_exp);
                m_run = 1;
            end else begin
                m_run++;
            end
            if (adc_cs_n) m_hi_run++; else m_hi_run = 0;
            if (res_valid) begin
                valids++;
                if (exp_a_q.size() == 0) begin
                    chk(1'b0, "R11", "unexpected result", 1, 0);
                end else begin
                    logic [15:0] ea, eb;
                    bit er;
                    ea = exp_a_q.pop_front(); eb = exp_b_q.pop_front(); er = exp_reg_q.pop_front();
                    chk(res_a === ea, frame_1w ? "R8" : "R7", "res_a", res_a, ea);
                    chk(res_b === eb, frame_1w ? "R8" : "R7", "res_b (R6 sampling)", res_b, eb);
                    chk(res_reg === er, "R11", "res_reg", res_reg, er);
                end
            end
        end
        m_cs_prev = adc_cs_n; m_sclk_prev = adc_sclk; m_sdi_prev = adc_sdi;
    end

    // ---------------- stimulus ----------------
    task automatic do_cmd(input logic [1:0] op, input logic [3:0] a, input logic [9:0] d);
        word_q.push_back(ref_word(op, a, d));
        @(negedge clk);
        cmd_req = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        do @(negedge clk); while (!cmd_ack);
        cmd_req = 1'b0;
    endtask

    task automatic drain();
        repeat (2) @(negedge clk);
        while (!adc_cs_n) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(adc_cs_n === 1'b1, "R1", "cs_n in reset", adc_cs_n, 1);
        chk(adc_sclk === 1'b1, "R1", "sclk in reset", adc_sclk, 1);
        chk(adc_sdi === 1'b0, "R1", "sdi in reset", adc_sdi, 0);
        chk(cmd_ack === 1'b0 && res_valid === 1'b0 && res_reg === 1'b0, "R1",
            "ack/valid/reg in reset", {cmd_ack, res_valid, res_reg}, 0);
        rst_n = 1'b1;

        // dual-lane streaming; first frame gives no result (R11)
        repeat (3) do_cmd(2'b00, 4'h0, 10'h0);
        // register write then read (R3, R11)
        do_cmd(2'b10, 4'h5, 10'h2A5);
        do_cmd(2'b01, 4'h5, 10'h155);
        do_cmd(2'b00, 4'h0, 10'h0);
        // single-lane mode (R8, R9)
        do_cmd(2'b10, 4'h2, 10'h001);
        repeat (3) do_cmd(2'b00, 4'h0, 10'h0);
        do_cmd(2'b01, 4'h5, 10'h0);
        do_cmd(2'b00, 4'h0, 10'h0);
        drain();
        cfg_half = 8'd1; cfg_gap = 8'd0;
        repeat (3) do_cmd(2'b00, 4'h0, 10'h0);
        // soft reset returns to dual lane (R10)
        do_cmd(2'b10, 4'h3, 10'h001);
        repeat (2) do_cmd(2'b00, 4'h0, 10'h0);
        // mode bit cleared by an explicit write (R9)
        do_cmd(2'b10, 4'h2, 10'h001);
        do_cmd(2'b00, 4'h0, 10'h0);
        do_cmd(2'b10, 4'h2, 10'h000);
        repeat (2) do_cmd(2'b00, 4'h0, 10'h0);
        drain();
        // half setting of zero acts as one (R4), wider gap (R12)
        cfg_half = 8'd0; cfg_gap = 8'd5;
        repeat (2) do_cmd(2'b00, 4'h0, 10'h0);
        drain();
        cfg_half = 8'd6; cfg_gap = 8'd1;
        repeat (2) do_cmd(2'b00, 4'h0, 10'h0);
        // no-op with non-zero fields sends zeros (R3)
        do_cmd(2'b00, 4'hF, 10'h3FF);
        do_cmd(2'b01, 4'h5, 10'h3FF);
        do_cmd(2'b00, 4'h0, 10'h0);
        drain();

        chk(acks == dev_frames, "R2", "acks per frame", acks, dev_frames);
        chk(valids == dev_frames - 1, "R11", "results per frame", valids, dev_frames - 1);
        chk(exp_a_q.size() == 0, "R11", "results outstanding", exp_a_q.size(), 0);
        chk(word_q.size() == 0, "R3", "command words outstanding", word_q.size(), 0);
        finish_run();
    end
endmodule